// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-bus master for Ethernet PHYs. Software programs a single 32-bit command word that holds the operation code, the PHY address, the register address and the data. Setting the start bit in that same word launches a transaction. The engine then produces a Clause 22 management frame on the MDC clock and MDIO data lines. It shows the transfer as busy until the frame is finished, and for a read it leaves the returned 16-bit value in the low half of the word.

The management clock comes from the system clock through a divider with a parameter for its half period. MDC stays low while the engine is idle. Output bits change on the falling MDC edge and input bits are sampled on the rising edge. Software polls the busy bit with a bounded timeout. After busy clears, it reads the data and the read-fail flag from the command word.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After synchronous active-low reset, the command word reads as all zeros, and `mdc`, `mdio_oe` and `mdio_o` are low.
- R2: The command word layout is: bits 31:30 read as zero; bit 29 is busy; bit 28 is read-fail; bits 27:26 are the opcode (2'b10 read, 2'b01 write); bits 25:21 are the PHY address; bits 20:16 are the register address; bits 15:0 are data. An accepted write with bit 29 clear stores bits 27:0 (except bit 28) and does not start a frame.
- R3: An accepted write with bit 29 set and a valid opcode sets busy on the next cycle. Busy stays set for exactly 128*DIV_HALF system cycles and then clears by itself.
- R4: MDC toggles every DIV_HALF system cycles while busy, so its period is 2*DIV_HALF cycles. MDC is low whenever the engine is idle, and `mdio_oe` is low after a frame ends.
- R5: A write frame drives, MSB first, 32 ones, start bits 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and the 16 data bits. `mdio_oe` is high for all 64 bits, and the line changes only on the falling MDC edge.
- R6: A read frame drives its first 46 bits (preamble, 01, opcode 10, the two addresses) and then releases `mdio_oe` for the last 18 bits. The 16 data bits are sampled MSB first on the rising MDC edge and are readable in bits 15:0 once busy clears.
- R7: Read-fail is set at the end of a read if `mdio_i` was high at the rising edge of the second turnaround bit. It is cleared when the next transaction starts. A write never sets it, and the data bits are still captured on a failed read.
- R8: Writes to the command word while busy is set are ignored. The running frame, and the fields read back afterwards, are unaffected.
- R9: A write with bit 29 set and opcode 2'b00 or 2'b11 stores its fields but does not start a frame: busy stays clear and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word write data |
| reg_rdata | output | 32 | Command word read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data input |

## Verification
The embedded assertions check rules that must hold on every cycle:
- MDC stays low when idle.
- The preamble bits are ones.
- The output enable stays off through a read's turnaround and data phase.
- Fields stay stable when a write arrives while busy.
- Read-fail only rises after a read.
- Busy only rises for a valid opcode.

Only the bench scenarios can show the rest:
- The exact bit order of whole frames across a sweep of PHY and register addresses.
- The busy duration and the MDC period counted in cycles.
- The captured read data and the fail flag for chosen PHY responses.
- That the fail flag is cleared by the following transaction.

// File: rtl/mdio_cmd_pkg.sv
// Package: shared constants and types of the management command engine.
// Assumes Clause 22 framing with a fixed 32-bit preamble.
package mdio_cmd_pkg;
    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
    localparam int TA_POS    = PRE_LEN + 4 + PHY_AW + REG_AW;
    localparam int CNT_W     = $clog2(FRAME_LEN);

    // Command word field positions
    localparam int BIT_START = 29;
    localparam int BIT_FAIL  = 28;
    localparam int OP_LO     = 26;
    localparam int PHY_LO    = 21;
    localparam int REG_LO    = 16;

    typedef enum logic [1:0] {
        OP_RSV0 = 2'b00,
        OP_WR   = 2'b01,
        OP_RD   = 2'b10,
        OP_RSV3 = 2'b11
    } mdio_op_e;
endpackage

// File: rtl/mdio_clk_div.sv
// Module: management clock divider.
// Produces MDC with a half period of DIV_HALF system cycles while run is
// high, plus one-cycle rise/fall events aligned to the edge that toggles MDC.
// Assumes DIV_HALF >= 1; MDC is forced low and the phase restarts when idle.
module mdio_clk_div #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_ev,
    output logic fall_ev
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [DW-1:0] TERM = DW'(DIV_HALF - 1);

    logic [DW-1:0] cnt;
    logic          tick;

    assign tick    = run && (cnt == TERM);
    assign rise_ev = tick && !mdc;
    assign fall_ev = tick && mdc;

    // Half-period counter and MDC toggle flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the management clock idles low
    p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer.
// Shifts out one 64-bit Clause 22 frame, one bit per MDC period, changing the
// output on fall events. For reads it releases the line at the turnaround,
// checks the second turnaround bit and shifts in 16 data bits on rise events.
// Assumes launch arrives only while no frame is active.
module mdio_frame_seq
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              ld_rd,
    input  logic [PHY_AW-1:0] ld_phy,
    input  logic [REG_AW-1:0] ld_reg,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fail
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] REL_BIT   = CNT_W'(TA_POS - 1);
    localparam logic [CNT_W-1:0] TA2_BIT   = CNT_W'(TA_POS + 1);
    localparam logic [CNT_W-1:0] DATA0_BIT = CNT_W'(TA_POS + 2);

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bitcnt;
    logic                 active;
    logic                 is_rd;
    logic                 oe_q;
    logic [DATA_W-1:0]    rd_shift;
    logic                 fail_q;
    logic [1:0]           op_bits;
    logic [1:0]           ta_bits;
    logic [DATA_W-1:0]    data_bits;

    assign done      = active && fall_ev && (bitcnt == LAST_BIT);
    assign mdio_oe   = oe_q;
    assign mdio_o    = oe_q && shreg[FRAME_LEN-1];
    assign rd_data   = rd_shift;
    assign rd_fail   = fail_q;
    assign op_bits   = ld_rd ? OP_RD : OP_WR;
    assign ta_bits   = ld_rd ? 2'b11 : 2'b10;
    assign data_bits = ld_rd ? {DATA_W{1'b1}} : ld_data;

    // Output shifter, bit counter and output enable, advanced on fall events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            active <= 1'b0;
            is_rd  <= 1'b0;
            oe_q   <= 1'b0;
        end else if (launch) begin
            shreg  <= {{PRE_LEN{1'b1}}, 2'b01, op_bits, ld_phy, ld_reg, ta_bits, data_bits};
            bitcnt <= '0;
            active <= 1'b1;
            is_rd  <= ld_rd;
            oe_q   <= 1'b1;
        end else if (active && fall_ev) begin
            if (bitcnt == LAST_BIT) begin
                active <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
                shreg  <= {shreg[FRAME_LEN-2:0], 1'b0};
                if (is_rd && (bitcnt == REL_BIT)) begin
                    oe_q <= 1'b0;
                end
            end
        end
    end

    // Input capture of the turnaround check and read data on rise events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_shift <= '0;
            fail_q   <= 1'b0;
        end else if (launch) begin
            fail_q <= 1'b0;
        end else if (active && rise_ev && is_rd) begin
            if (bitcnt == TA2_BIT) begin
                fail_q <= mdio_i;
            end
            if (bitcnt >= DATA0_BIT) begin
                rd_shift <= {rd_shift[DATA_W-2:0], mdio_i};
            end
        end
    end

    // R5: every preamble bit driven is a one
    p_preamble_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mdio_oe && (bitcnt < CNT_W'(PRE_LEN))) |-> mdio_o);

    // R6: a read never drives the line from the turnaround onward
    p_read_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_rd && (bitcnt >= CNT_W'(TA_POS))) |-> !mdio_oe);

    // R3: the frame ends on the fall that completes the last bit
    p_frame_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!active && !mdio_oe));
endmodule

// File: rtl/mdio_cmd_reg.sv
// Module: command word register.
// Holds opcode, addresses, data, busy and read-fail. It accepts writes only
// while idle, starts a frame on a valid opcode with the start bit set, and
// folds the read result back in when the frame completes.
module mdio_cmd_reg
    import mdio_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rd_fail,
    output logic [31:0]       reg_rdata,
    output logic              launch
);
    mdio_op_e          op_q;
    logic [PHY_AW-1:0] phy_q;
    logic [REG_AW-1:0] reg_q;
    logic [DATA_W-1:0] data_q;
    logic              busy_q;
    logic              fail_q;
    logic              wr_ok;
    mdio_op_e          op_in;
    logic              unused_bits;

    assign wr_ok       = reg_wr && !busy_q;
    assign op_in       = mdio_op_e'(reg_wdata[OP_LO+1:OP_LO]);
    assign launch      = wr_ok && reg_wdata[BIT_START] && ((op_in == OP_RD) || (op_in == OP_WR));
    assign reg_rdata   = {2'b00, busy_q, fail_q, op_q, phy_q, reg_q, data_q};
    assign unused_bits = ^{reg_wdata[31:30], reg_wdata[BIT_FAIL]};

    // Field storage, busy and fail update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_RSV0;
            phy_q  <= '0;
            reg_q  <= '0;
            data_q <= '0;
            busy_q <= 1'b0;
            fail_q <= 1'b0;
        end else if (wr_ok) begin
            op_q   <= op_in;
            phy_q  <= reg_wdata[PHY_LO +: PHY_AW];
            reg_q  <= reg_wdata[REG_LO +: REG_AW];
            data_q <= reg_wdata[DATA_W-1:0];
            if (launch) begin
                busy_q <= 1'b1;
                fail_q <= 1'b0;
            end
        end else if (done) begin
            busy_q <= 1'b0;
            if (op_q == OP_RD) begin
                data_q <= rd_data;
                fail_q <= rd_fail;
            end
        end
    end

    // R8: a write while busy leaves the stored fields unchanged
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && reg_wr) |=> ($stable(op_q) && $stable(phy_q) && $stable(reg_q)));

    // R7: read-fail only ever rises after a read
    p_fail_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> (op_q == OP_RD));

    // R9: busy only rises for a valid opcode
    p_busy_valid_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |-> ((op_q == OP_RD) || (op_q == OP_WR)));
endmodule

// File: rtl/mdio_cmd_engine.sv
// Module: management command engine top.
// Ties the command word register, the clock divider and the frame sequencer
// together. The divider runs exactly while the command word shows busy.
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              launch;
    logic              done;
    logic              rise_ev;
    logic              fall_ev;
    logic [DATA_W-1:0] rd_data;
    logic              rd_fail;
    logic              run;

    assign run = reg_rdata[BIT_START];

    mdio_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .done      (done),
        .rd_data   (rd_data),
        .rd_fail   (rd_fail),
        .reg_rdata (reg_rdata),
        .launch    (launch)
    );

    mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mdc     (mdc),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    mdio_frame_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .ld_rd   (reg_wdata[OP_LO+1:OP_LO] == OP_RD),
        .ld_phy  (reg_wdata[PHY_LO +: PHY_AW]),
        .ld_reg  (reg_wdata[REG_LO +: REG_AW]),
        .ld_data (reg_wdata[DATA_W-1:0]),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .mdio_i  (mdio_i),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done    (done),
        .rd_data (rd_data),
        .rd_fail (rd_fail)
    );
endmodule

// File: tb/mdio_cmd_engine_tb_top.sv
// Bench: sweeps write and read transactions over all PHY and register
// addresses, with a bench-side PHY model, and checks against values it
// computes itself.
module mdio_cmd_engine_tb_top;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 0;

    // PHY model state
    int          k = 0;
    logic [63:0] cap = '0;
    logic [63:0] oem = '0;
    logic [15:0] resp = '0;
    bit          ta_low = 1;
    int          rises = 0;
    int          ncnt = 0;
    int          period = 0;
    logic        mdc_prev = 1'b0;

    mdio_cmd_engine #(.DIV_HALF(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // PHY model: captures driven bits on MDC rise, then presents the next input bit
    always @(posedge mdc) begin
        rises++;
        if (k < 64) begin
            if (mdio_oe) begin
                cap[63-k] = mdio_o;
                oem[63-k] = 1'b1;
            end
        end
        k = k + 1;
        if (k == 47) mdio_i = ta_low ? 1'b0 : 1'b1;
        else if (k >= 48 && k < 64) mdio_i = resp[63-k];
        else mdio_i = 1'b1;
    end

    // MDC period measurement in system cycles
    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            period = ncnt + 1;
            ncnt = 0;
        end else begin
            ncnt++;
        end
        mdc_prev = mdc;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_word(input logic [31:0] w);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [31:0] mk(input logic st, input logic [1:0] op,
                                       input logic [4:0] p, input logic [4:0] r,
                                       input logic [15:0] d);
        return {2'b00, st, 1'b0, op, p, r, d};
    endfunction

    // One transaction with a bus model response; optional write while busy
    task automatic txn(input bit rd, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d, input logic [15:0] rsp,
                       input bit tlow, input bit junk);
        int bc;
        logic [63:0] ef;
        logic [63:0] em;
        logic [31:0] er;
        resp = rsp;
        ta_low = tlow;
        k = 0;
        cap = '0;
        oem = '0;
        mdio_i = 1'b1;
        wr_word(mk(1'b1, rd ? 2'b10 : 2'b01, p, r, d));
        bc = 0;
        while (reg_rdata[29] && bc < 2000) begin
            bc++;
            if (junk && bc == 50) begin
                reg_wr = 1'b1;
                reg_wdata = {2'b00, 1'b1, 1'b1, 2'b01, 5'h1f ^ p, 5'h15 ^ r, ~d};
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0;
        check("R3 busy cycles", 64'(bc), 64'(128 * DIV));
        if (rd) begin
            ef = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r, 18'h0};
            em = 64'hFFFF_FFFF_FFFC_0000;
            er = {2'b00, 1'b0, ~tlow, 2'b10, p, r, rsp};
            check("R6 read frame", cap & em, ef);
            check("R6 read oe mask", oem, em);
            check(tlow ? "R6 read data" : "R7 read fail", 64'(reg_rdata), 64'(er));
        end else begin
            ef = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
            check("R5 write frame", cap, ef);
            check("R5 write oe mask", oem, 64'hFFFF_FFFF_FFFF_FFFF);
            er = {2'b00, 1'b0, 1'b0, 2'b01, p, r, d};
            check(junk ? "R8 busy write ignored" : "R2 write readback", 64'(reg_rdata), 64'(er));
        end
        check("R4 idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset rdata", 64'(reg_rdata), 64'h0);
        check("R1 reset pins", {61'h0, mdc, mdio_oe, mdio_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 64'(reg_rdata), 64'h0);

        // R2 write without start stores fields only
        r0 = rises;
        wr_word(mk(1'b0, 2'b01, 5'd3, 5'd7, 16'hBEEF));
        repeat (10) @(negedge clk);
        check("R2 store no start", 64'(reg_rdata), 64'(mk(1'b0, 2'b01, 5'd3, 5'd7, 16'hBEEF)));
        check("R2 no mdc activity", 64'(rises - r0), 64'h0);

        // R9 invalid opcodes do not launch
        wr_word(mk(1'b1, 2'b00, 5'd9, 5'd2, 16'h1357));
        repeat (10) @(negedge clk);
        check("R9 op00 no launch", 64'(reg_rdata), 64'(mk(1'b0, 2'b00, 5'd9, 5'd2, 16'h1357)));
        wr_word(mk(1'b1, 2'b11, 5'd4, 5'd30, 16'h2468));
        repeat (10) @(negedge clk);
        check("R9 op11 no launch", 64'(reg_rdata), 64'(mk(1'b0, 2'b11, 5'd4, 5'd30, 16'h2468)));
        check("R9 mdc never toggled", 64'(rises - r0), 64'h0);

        // Write sweep over every PHY address
        for (int p = 0; p < 32; p++) begin
            txn(1'b0, 5'(p), 5'(31 - p), 16'(p * 16'h0A3D + 16'h1234), 16'h0, 1'b1, (p % 8) == 3);
            if (p == 0) check("R4 mdc period", 64'(period), 64'(2 * DIV));
        end

        // Read sweep over every register address
        for (int r = 0; r < 32; r++) begin
            txn(1'b1, 5'(r * 7), 5'(r), 16'h0, 16'(r * 16'h3C5A) ^ 16'h5A5A, 1'b1, (r % 8) == 5);
        end

        // R7 read-fail cases, then a write that clears the flag
        txn(1'b1, 5'd1, 5'd2, 16'h0, 16'hFFFF, 1'b0, 1'b0);
        txn(1'b1, 5'd17, 5'd9, 16'h0, 16'hA5C3, 1'b0, 1'b0);
        txn(1'b0, 5'd5, 5'd6, 16'h0F0F, 16'h0, 1'b1, 1'b0);
        check("R7 fail cleared by next", 64'(reg_rdata[28]), 64'h0);
        txn(1'b1, 5'd30, 5'd31, 16'h0, 16'h8001, 1'b0, 1'b0);
        txn(1'b1, 5'd30, 5'd31, 16'h0, 16'h8001, 1'b1, 1'b0);
        check("R7 fail cleared by read", 64'(reg_rdata[28]), 64'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule